// File: doc/BRIEF.md
# Keyed Flash Command Controller

This block controls a small on-chip nonvolatile word array through a register bus. Software sets a microsecond reload value, loads a data word and a byte address, and then writes a command word. The command runs only when the command word carries the correct 16-bit key in its upper half. The block can program one word, erase one 1 KB page, or erase the whole array. A program clears bits and never sets them, so the stored word becomes the AND of the old contents and the new data. An erase returns every bit it covers to 1.

The array is split into 2 KB protection blocks, and a static input vector marks which blocks are locked. A free-running prescaler divides the clock down to a 1 MHz reference tick, and each operation lasts a set number of these ticks. The command bit reads back as set while the operation is in progress, so software can poll it. Completion and access faults are recorded in a raw status register. A mask register selects which of these two conditions drive the interrupt output, and a write-one-to-clear register acknowledges them. Bus reads with the top address bit set return array words.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: The reload register (offset 0x00, 8 bits) sets the reference tick period to reload+1 clocks. A word program lasts PROG_TICKS ticks, a page erase PERASE_TICKS ticks and a mass erase MERASE_TICKS ticks. With reload 3, a program keeps busy high for 7 to 10 cycles. With reload 15, it keeps busy high for 19 to 34 cycles.
- R2: A write to the command register (offset 0x0C) takes effect only if bits 31:16 equal 0xA442. With any other key, nothing starts and the array is left unchanged.
- R3: Command bit 0 selects a word program, bit 1 a page erase and bit 2 a mass erase. A keyed write in which bits 2:0 hold zero bits or more than one set bit starts nothing.
- R4: While an operation runs, its command bit reads back as 1 in the command register and busy is high. When the operation ends, the command bit returns to 0, busy falls, and raw status bit 1 (done) is set.
- R5: A word program replaces the word at the address register (offset 0x08) with the AND of that word and the data register (offset 0x04).
- R6: A page erase sets every word of the 1 KB page that holds the address to 0xFFFFFFFF. The low 10 address bits are ignored, and other pages are not changed.
- R7: A mass erase sets every word of each unprotected block to 0xFFFFFFFF and skips protected blocks. If any block was skipped, raw status bit 0 (violation) is set.
- R8: A program or page erase aimed at a 2 KB block whose protection input bit is 1 leaves the array unchanged and sets raw status bits 0 and 1.
- R9: A program or page erase with an address at or above ARRAY_BYTES leaves the array unchanged and sets raw status bits 0 and 1.
- R10: The irq output is high while any raw status bit (offset 0x10) has its mask bit (offset 0x14) set. Offset 0x18 reads raw AND mask. Writing 1 to a bit at offset 0x18 clears that raw bit, and writing 0 leaves it.
- R11: A command write made while busy is high is ignored. The running command is unchanged, and nothing starts afterwards.
- R12: A word program ignores the low 2 address bits. The neighbouring word is not changed.
- R13: After reset, reload, raw status, mask and the command register read 0, and busy and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus request for this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | BUS_AW | Byte address; top bit set selects the array window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after the request |
| protBlk | input | ARRAY_BYTES/BLOCK_BYTES | One lock bit per 2 KB block |
| irq | output | 1 | Masked status interrupt |
| busy | output | 1 | High while an operation runs |

## Verification
The assertions assume that protBlk changes only while busy is low. They also assume a single bus master that issues one-cycle requests, so a command write and a status clear never fall in the same cycle as an unrelated register write. The directed stimulus follows these rules. It changes the lock vector only between operations and waits for busy to fall before it reads any result. The only commands sent during a busy window are the ones that test R11 on purpose.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;
  localparam logic [15:0] CMD_KEY = 16'hA442;

  // register slots, selected by byte address bits 4:2
  localparam logic [2:0] SLOT_RELOAD = 3'd0;
  localparam logic [2:0] SLOT_DATA   = 3'd1;
  localparam logic [2:0] SLOT_ADDR   = 3'd2;
  localparam logic [2:0] SLOT_CMD    = 3'd3;
  localparam logic [2:0] SLOT_RAW    = 3'd4;
  localparam logic [2:0] SLOT_MASK   = 3'd5;
  localparam logic [2:0] SLOT_MIS    = 3'd6;

  typedef enum logic [2:0] {
    S_IDLE,
    S_APPLY,
    S_WALK,
    S_HOLD,
    S_FINISH
  } nvmState_e;

  // strobes from the sequencer to the array datapath
  typedef struct packed {
    logic        progEn;
    logic        eraseEn;
    logic [15:0] eraseIdx;
  } nvmStrobe_t;
endpackage

// File: rtl/nvm_cmd_dp.sv
module nvm_cmd_dp
  import nvm_cmd_pkg::*;
#(
  parameter int ARRAY_BYTES = 4096,
  parameter int BUS_AW = 16,
  localparam int WORDS = ARRAY_BYTES / 4,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              wrDataReg,
  input  logic              wrAddrReg,
  input  logic [31:0]       regRdVal,
  input  nvmStrobe_t        stb,
  output logic [31:0]       dataReg,
  output logic [31:0]       addrReg,
  output logic [31:0]       busRdata
);
  logic [31:0] mem [WORDS];
  logic [WIDX_W-1:0] progIdx;
  logic [WIDX_W-1:0] rdIdx;
  logic unusedBits;

  assign progIdx = addrReg[WIDX_W+1:2];
  assign rdIdx   = busAddr[WIDX_W+1:2];
  assign unusedBits = ^{stb.eraseIdx, busAddr};

  // array cells: erase forces ones, program can only clear bits
  always_ff @(posedge clk) begin
    if (stb.eraseEn) mem[stb.eraseIdx[WIDX_W-1:0]] <= '1;
    if (stb.progEn)  mem[progIdx] <= mem[progIdx] & dataReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg  <= '0;
      addrReg  <= '0;
      busRdata <= '0;
    end else begin
      if (wrDataReg) dataReg <= busWdata;
      if (wrAddrReg) addrReg <= busWdata;
      if (busValid && !busWrite)
        busRdata <= busAddr[BUS_AW-1] ? mem[rdIdx] : regRdVal;
    end
  end
endmodule

// File: rtl/nvm_cmd_ctl.sv
module nvm_cmd_ctl
  import nvm_cmd_pkg::*;
#(
  parameter int ARRAY_BYTES = 4096,
  parameter int PAGE_BYTES = 1024,
  parameter int BLOCK_BYTES = 2048,
  parameter int PROG_TICKS = 2,
  parameter int PERASE_TICKS = 8,
  parameter int MERASE_TICKS = 16,
  parameter int BUS_AW = 16,
  localparam int WORDS = ARRAY_BYTES / 4,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int NUM_BLOCKS = ARRAY_BYTES / BLOCK_BYTES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busValid,
  input  logic                  busWrite,
  input  logic [BUS_AW-1:0]     busAddr,
  input  logic [31:0]           busWdata,
  input  logic [NUM_BLOCKS-1:0] protBlk,
  input  logic [31:0]           dataReg,
  input  logic [31:0]           addrReg,
  output logic                  wrDataReg,
  output logic                  wrAddrReg,
  output logic [31:0]           regRdVal,
  output nvmStrobe_t            stb,
  output logic                  busy,
  output logic                  irq,
  output logic [2:0]            cmdActive,
  output logic [1:0]            rawStat,
  output logic                  tick,
  output logic [7:0]            reloadVal
);
  localparam int PAGE_WORDS = PAGE_BYTES / 4;
  localparam int BLK_SHIFT = $clog2(BLOCK_BYTES / 4);
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  localparam int MAX_A = (PROG_TICKS > PERASE_TICKS) ? PROG_TICKS : PERASE_TICKS;
  localparam int MAX_TICKS = (MAX_A > MERASE_TICKS) ? MAX_A : MERASE_TICKS;
  localparam int TICK_W = $clog2(MAX_TICKS + 1);

  nvmState_e state;
  logic [7:0] preCnt;
  logic [1:0] maskReg, rawNext;
  logic [TICK_W-1:0] tickCnt, durLast;
  logic [WIDX_W-1:0] walkIdx, walkEnd, wordIdx, pageBase, tgtBlkFull, walkBlkFull;
  logic faultFlag, tgtProt, walkProt, inRange;
  logic wrReg, cmdAccept;
  logic [2:0] slot;
  logic unusedBits;

  assign slot      = busAddr[4:2];
  assign wrReg     = busValid && busWrite && !busAddr[BUS_AW-1];
  assign wrDataReg = wrReg && (slot == SLOT_DATA);
  assign wrAddrReg = wrReg && (slot == SLOT_ADDR);
  assign cmdAccept = wrReg && (slot == SLOT_CMD) && (state == S_IDLE)
                     && (busWdata[31:16] == CMD_KEY) && $onehot(busWdata[2:0]);
  assign unusedBits = ^{busAddr, busWdata[15:8]};

  // target address decode
  assign wordIdx     = addrReg[WIDX_W+1:2];
  assign inRange     = addrReg < 32'(ARRAY_BYTES);
  assign pageBase    = wordIdx & ~(WIDX_W'(PAGE_WORDS - 1));
  assign tgtBlkFull  = wordIdx >> BLK_SHIFT;
  assign walkBlkFull = walkIdx >> BLK_SHIFT;
  assign tgtProt     = protBlk[tgtBlkFull[BLK_W-1:0]];
  assign walkProt    = protBlk[walkBlkFull[BLK_W-1:0]];

  // prescaler tick
  assign tick = (preCnt == 8'd0);

  always_comb begin
    unique case (1'b1)
      cmdActive[2]: durLast = TICK_W'(MERASE_TICKS - 1);
      cmdActive[1]: durLast = TICK_W'(PERASE_TICKS - 1);
      default:      durLast = TICK_W'(PROG_TICKS - 1);
    endcase
  end

  always_comb begin
    stb          = '0;
    stb.progEn   = (state == S_APPLY) && cmdActive[0] && inRange && !tgtProt;
    stb.eraseEn  = (state == S_WALK) && !walkProt;
    stb.eraseIdx = 16'(walkIdx);
  end

  always_comb begin
    rawNext = rawStat;
    if (wrReg && (slot == SLOT_MIS)) rawNext = rawNext & ~busWdata[1:0];
    if (state == S_FINISH) begin
      rawNext[1] = 1'b1;
      rawNext[0] = rawNext[0] | faultFlag;
    end
  end

  always_comb begin
    unique case (slot)
      SLOT_RELOAD: regRdVal = {24'd0, reloadVal};
      SLOT_DATA:   regRdVal = dataReg;
      SLOT_ADDR:   regRdVal = addrReg;
      SLOT_CMD:    regRdVal = {29'd0, cmdActive};
      SLOT_RAW:    regRdVal = {30'd0, rawStat};
      SLOT_MASK:   regRdVal = {30'd0, maskReg};
      SLOT_MIS:    regRdVal = {30'd0, rawStat & maskReg};
      default:     regRdVal = '0;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign irq  = |(rawStat & maskReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      preCnt    <= '0;
      reloadVal <= '0;
      maskReg   <= '0;
      rawStat   <= '0;
      cmdActive <= '0;
      tickCnt   <= '0;
      walkIdx   <= '0;
      walkEnd   <= '0;
      faultFlag <= 1'b0;
    end else begin
      preCnt  <= tick ? reloadVal : preCnt - 8'd1;
      rawStat <= rawNext;
      if (wrReg && (slot == SLOT_RELOAD)) reloadVal <= busWdata[7:0];
      if (wrReg && (slot == SLOT_MASK))   maskReg   <= busWdata[1:0];
      unique case (state)
        S_IDLE: begin
          if (cmdAccept) begin
            cmdActive <= busWdata[2:0];
            state     <= S_APPLY;
          end
        end
        S_APPLY: begin
          tickCnt <= '0;
          if (cmdActive[2]) begin
            walkIdx   <= '0;
            walkEnd   <= WIDX_W'(WORDS - 1);
            faultFlag <= |protBlk;
            state     <= S_WALK;
          end else if (!inRange || tgtProt) begin
            faultFlag <= 1'b1;
            state     <= S_FINISH;
          end else if (cmdActive[0]) begin
            state <= S_HOLD;
          end else begin
            walkIdx <= pageBase;
            walkEnd <= pageBase + WIDX_W'(PAGE_WORDS - 1);
            state   <= S_WALK;
          end
        end
        S_WALK: begin
          if (walkIdx == walkEnd) state <= S_HOLD;
          else walkIdx <= walkIdx + WIDX_W'(1);
        end
        S_HOLD: begin
          if (tick) begin
            if (tickCnt == durLast) state <= S_FINISH;
            else tickCnt <= tickCnt + TICK_W'(1);
          end
        end
        S_FINISH: begin
          cmdActive <= '0;
          faultFlag <= 1'b0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
  import nvm_cmd_pkg::*;
#(
  parameter int ARRAY_BYTES = 4096,
  parameter int PAGE_BYTES = 1024,
  parameter int BLOCK_BYTES = 2048,
  parameter int PROG_TICKS = 2,
  parameter int PERASE_TICKS = 8,
  parameter int MERASE_TICKS = 16,
  parameter int BUS_AW = 16,
  localparam int NUM_BLOCKS = ARRAY_BYTES / BLOCK_BYTES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busValid,
  input  logic                  busWrite,
  input  logic [BUS_AW-1:0]     busAddr,
  input  logic [31:0]           busWdata,
  output logic [31:0]           busRdata,
  input  logic [NUM_BLOCKS-1:0] protBlk,
  output logic                  irq,
  output logic                  busy
);
  nvmStrobe_t stb;
  logic [31:0] dataReg, addrReg, regRdVal;
  logic wrDataReg, wrAddrReg, tick;
  logic [2:0] cmdActive;
  logic [1:0] rawStat;
  logic [7:0] reloadVal;

  nvm_cmd_ctl #(
    .ARRAY_BYTES(ARRAY_BYTES), .PAGE_BYTES(PAGE_BYTES), .BLOCK_BYTES(BLOCK_BYTES),
    .PROG_TICKS(PROG_TICKS), .PERASE_TICKS(PERASE_TICKS), .MERASE_TICKS(MERASE_TICKS),
    .BUS_AW(BUS_AW)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .protBlk(protBlk),
    .dataReg(dataReg), .addrReg(addrReg), .wrDataReg(wrDataReg), .wrAddrReg(wrAddrReg),
    .regRdVal(regRdVal), .stb(stb), .busy(busy), .irq(irq), .cmdActive(cmdActive),
    .rawStat(rawStat), .tick(tick), .reloadVal(reloadVal)
  );

  nvm_cmd_dp #(.ARRAY_BYTES(ARRAY_BYTES), .BUS_AW(BUS_AW)) u_dp (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .wrDataReg(wrDataReg), .wrAddrReg(wrAddrReg),
    .regRdVal(regRdVal), .stb(stb), .dataReg(dataReg), .addrReg(addrReg),
    .busRdata(busRdata)
  );
endmodule

// File: rtl/nvm_cmd_chk.sv
module nvm_cmd_chk #(
  parameter int BUS_AW = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [BUS_AW-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              busy,
  input logic              irq,
  input logic [2:0]        cmdActive,
  input logic [1:0]        rawStat,
  input logic              tick,
  input logic [7:0]        reloadVal
);
  logic cmdWr, badKey;
  logic unusedBits;
  assign cmdWr  = busValid && busWrite && !busAddr[BUS_AW-1] && (busAddr[4:2] == 3'd3);
  assign badKey = busWdata[31:16] != 16'hA442;
  assign unusedBits = ^{busAddr, busWdata[15:0]};

  a_r4_busy_matches_cmd: assert property (@(posedge clk) disable iff (!rstN)
    busy == (cmdActive != 3'd0));
  a_r3_cmd_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdActive));
  a_r4_done_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> rawStat[1]);
  a_r2_bad_key: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdWr && badKey) |=> !busy);
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (cmdActive == $past(cmdActive)) || (cmdActive == 3'd0));
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (tick && reloadVal != 8'd0) |=> !tick);
  a_r10_irq_needs_raw: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (rawStat != 2'd0));
endmodule

bind nvm_cmd_ctrl nvm_cmd_chk #(.BUS_AW(BUS_AW)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busy(busy), .irq(irq),
  .cmdActive(cmdActive), .rawStat(rawStat), .tick(tick), .reloadVal(reloadVal)
);

// File: tb/nvm_cmd_ctrl_tb.sv
module nvm_cmd_ctrl_tb;
  localparam logic [15:0] A_RELOAD = 16'h0000, A_DATA = 16'h0004, A_ADDR = 16'h0008,
                          A_CMD = 16'h000C, A_RAW = 16'h0010, A_MASK = 16'h0014,
                          A_MIS = 16'h0018, A_ARR = 16'h8000;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 1'b0, rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [1:0] protBlk = 2'b00;
  logic irq, busy;
  int checks = 0, fails = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  nvm_cmd_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .protBlk(protBlk), .irq(irq), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chkRange(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 8000) begin
      @(negedge clk);
      n++;
    end
    chk("R4 busy ends", {31'd0, busy}, 32'd0);
  endtask

  task automatic runCmd(input logic [2:0] bits);
    wr(A_CMD, {16'hA442, 13'd0, bits});
    waitIdle();
  endtask

  task automatic doProg(input logic [31:0] a, input logic [31:0] d);
    wr(A_DATA, d);
    wr(A_ADDR, a);
    runCmd(3'b001);
  endtask

  task automatic doErase(input logic [31:0] a);
    wr(A_ADDR, a);
    runCmd(3'b010);
  endtask

  task automatic rdArr(input logic [31:0] a, output logic [31:0] d);
    rd(A_ARR | a[15:0], d);
  endtask

  task automatic tReset();
    rd(A_RELOAD, rv); chk("R13 reload", rv, 32'd0);
    rd(A_RAW, rv);    chk("R13 raw", rv, 32'd0);
    rd(A_MASK, rv);   chk("R13 mask", rv, 32'd0);
    rd(A_CMD, rv);    chk("R13 cmd", rv, 32'd0);
    chk("R13 busy", {31'd0, busy}, 32'd0);
    chk("R13 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic tMassErase();
    wr(A_RELOAD, 32'd3);
    runCmd(3'b100);
    rdArr(32'h000, rv); chk("R7 mass word0", rv, ONES);
    rdArr(32'h7FC, rv); chk("R7 mass mid", rv, ONES);
    rdArr(32'hFFC, rv); chk("R7 mass last", rv, ONES);
    rd(A_RAW, rv);      chk("R7 raw no skip", rv, 32'd2);
    wr(A_MIS, 32'd3);
  endtask

  task automatic tProgram();
    doProg(32'h010, 32'hF0F0_A5A5);
    rdArr(32'h010, rv); chk("R5 program", rv, 32'hF0F0_A5A5);
    doProg(32'h013, 32'h0FFF_FFFF);
    rdArr(32'h010, rv); chk("R5 R12 and-merge", rv, 32'h00F0_A5A5);
    rdArr(32'h014, rv); chk("R12 neighbour", rv, ONES);
  endtask

  task automatic tPoll();
    wr(A_DATA, 32'h1234_5678);
    wr(A_ADDR, 32'h020);
    wr(A_CMD, {16'hA442, 16'h0001});
    rd(A_CMD, rv); chk("R4 cmd bit while busy", rv, 32'd1);
    waitIdle();
    rd(A_CMD, rv); chk("R4 cmd bit cleared", rv, 32'd0);
    rd(A_RAW, rv); chk("R4 done bit", rv & 32'd2, 32'd2);
    wr(A_MIS, 32'd3);
  endtask

  task automatic tKey();
    wr(A_ADDR, 32'h000);
    wr(A_CMD, 32'h1234_0002);
    @(negedge clk);
    chk("R2 bad key no busy", {31'd0, busy}, 32'd0);
    rdArr(32'h010, rv); chk("R2 array kept", rv, 32'h00F0_A5A5);
    wr(A_CMD, {16'hA442, 16'h0003});
    @(negedge clk);
    chk("R3 two bits no busy", {31'd0, busy}, 32'd0);
    wr(A_CMD, {16'hA442, 16'h0000});
    rd(A_CMD, rv); chk("R3 no bits no start", rv, 32'd0);
    rdArr(32'h010, rv); chk("R3 array kept", rv, 32'h00F0_A5A5);
  endtask

  task automatic tPageErase();
    doProg(32'h400, 32'h0000_1234);
    doProg(32'h800, 32'hAAAA_0000);
    rdArr(32'h400, rv); chk("R6 pre", rv, 32'h0000_1234);
    doErase(32'h4FF);
    rdArr(32'h400, rv); chk("R6 page base", rv, ONES);
    rdArr(32'h7FC, rv); chk("R6 page end", rv, ONES);
    rdArr(32'h010, rv); chk("R6 lower page kept", rv, 32'h00F0_A5A5);
    rdArr(32'h800, rv); chk("R6 upper page kept", rv, 32'hAAAA_0000);
    wr(A_MIS, 32'd3);
  endtask

  task automatic tBusyIgnore();
    wr(A_DATA, 32'd0);
    wr(A_ADDR, 32'h000);
    wr(A_CMD, {16'hA442, 16'h0002});
    wr(A_CMD, {16'hA442, 16'h0001});
    rd(A_CMD, rv); chk("R11 cmd unchanged", rv, 32'd2);
    waitIdle();
    repeat (4) @(negedge clk);
    chk("R11 no late start", {31'd0, busy}, 32'd0);
    rdArr(32'h010, rv); chk("R11 erased not programmed", rv, ONES);
    rdArr(32'h000, rv); chk("R11 word0", rv, ONES);
    wr(A_MIS, 32'd3);
  endtask

  task automatic tProtect();
    protBlk = 2'b10;
    doProg(32'h900, 32'd0);
    rdArr(32'h900, rv); chk("R8 prog blocked", rv, ONES);
    rd(A_RAW, rv);      chk("R8 raw prog", rv, 32'd3);
    wr(A_MIS, 32'd3);
    doErase(32'h800);
    rdArr(32'h800, rv); chk("R8 erase blocked", rv, 32'hAAAA_0000);
    rd(A_RAW, rv);      chk("R8 raw erase", rv, 32'd3);
    wr(A_MIS, 32'd3);
  endtask

  task automatic tRange();
    doProg(32'h1000, 32'd0);
    rdArr(32'h000, rv); chk("R9 alias word kept", rv, ONES);
    rd(A_RAW, rv);      chk("R9 raw", rv, 32'd3);
    wr(A_MIS, 32'd3);
  endtask

  task automatic tMassSkip();
    doProg(32'h040, 32'd0);
    rdArr(32'h040, rv); chk("R7 pre", rv, 32'd0);
    wr(A_MIS, 32'd3);
    runCmd(3'b100);
    rdArr(32'h040, rv); chk("R7 open block erased", rv, ONES);
    rdArr(32'h800, rv); chk("R7 locked block kept", rv, 32'hAAAA_0000);
    rd(A_RAW, rv);      chk("R7 skip flag", rv, 32'd3);
    wr(A_MIS, 32'd3);
    protBlk = 2'b00;
  endtask

  task automatic tIrq();
    doProg(32'h2000, 32'd0);
    wr(A_MASK, 32'd0);
    @(negedge clk);
    chk("R10 masked off", {31'd0, irq}, 32'd0);
    wr(A_MASK, 32'd2);
    @(negedge clk);
    chk("R10 irq on", {31'd0, irq}, 32'd1);
    rd(A_MIS, rv); chk("R10 masked read", rv, 32'd2);
    wr(A_MIS, 32'd1);
    rd(A_RAW, rv); chk("R10 w1c bit0", rv, 32'd2);
    wr(A_MIS, 32'd0);
    rd(A_RAW, rv); chk("R10 w0 no effect", rv, 32'd2);
    wr(A_MIS, 32'd2);
    rd(A_RAW, rv); chk("R10 w1c bit1", rv, 32'd0);
    chk("R10 irq off", {31'd0, irq}, 32'd0);
    wr(A_MASK, 32'd0);
  endtask

  task automatic measure(input logic [7:0] rl, output int len);
    wr(A_RELOAD, {24'd0, rl});
    wr(A_DATA, ONES);
    wr(A_ADDR, 32'h100);
    wr(A_CMD, {16'hA442, 16'h0001});
    len = 0;
    while (busy && len < 1000) begin
      len++;
      @(negedge clk);
    end
    wr(A_MIS, 32'd3);
  endtask

  task automatic tTick();
    int len;
    measure(8'd3, len);
    chkRange("R1 reload 3", len, 7, 10);
    measure(8'd15, len);
    chkRange("R1 reload 15", len, 19, 34);
    rd(A_RELOAD, rv); chk("R1 reload readback", rv, 32'd15);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tMassErase();
    tProgram();
    tPoll();
    tKey();
    tPageErase();
    tBusyIgnore();
    tProtect();
    tRange();
    tMassSkip();
    tIrq();
    tTick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule